// File: doc/BRIEF.md
# Fractional SCL Tick Divider

This block derives the timing tick for a serial-bus master's clock line from a fixed 100 MHz kernel clock. It does not count down an integer. It keeps a phase accumulator: each kernel clock adds an increment value, and when the running sum reaches a modulus of (decrement + 1) the block emits a one-cycle tick and removes one modulus from the sum. A ratio of increment to modulus that is not a whole number therefore gives a tick rate with an exact long-term average. The SCL square wave flips on every tick, so one SCL period spans two ticks.

Two configuration banks are kept. Bank 0 serves standard and fast mode, and bank 1 serves high-speed mode. Each bank is one 32-bit word. The increment sits in the upper half and the decrement in the lower half. A speed-select input chooses which bank drives the accumulator. Software loads the banks while the run input is low and then raises run. Any bank write made while run is high is dropped. Typical settings at 100 MHz are as follows:
- Standard mode at 100 kHz: bank 0 set to increment 1, decrement 499.
- Fast mode at 400 kHz: bank 0 set to increment 1, decrement 124.
- High-speed mode: bank 1 set to increment 41, decrement 152, with the unused bank left at zero.

Top module: `scl_frac_div`

## Requirements
- R1: After synchronous reset, `tick` is 0, `scl` is 1 and both banks hold zero.
- R2: A configuration word carries the increment in bits 31:16 and the decrement in bits 15:0. `cfg_sel` = 0 writes bank 0 and `cfg_sel` = 1 writes bank 1. Writes take effect at the clock edge where `cfg_wr` is high.
- R3: With increment 1 and decrement D, `tick` pulses once every D+1 clocks while running. The first pulse appears after the (D+1)-th rising edge at which `run_en` was sampled high.
- R4: With increment I ≤ D+1, `tick` is high after the k-th running edge exactly when floor(k·I/(D+1)) exceeds floor((k−1)·I/(D+1)).
- R5: `scl` inverts at each tick and holds its value on every running cycle without a tick. It starts high when a run begins.
- R6: `tick` is a registered single-cycle pulse and is never high unless `run_en` was high at the previous edge.
- R7: An active bank with increment 0 (including an all-zero bank) produces no ticks, and `scl` stays high.
- R8: Bank writes while `run_en` is high have no effect on the stored configuration or on later runs.
- R9: One edge after `run_en` is sampled low, `tick` is 0 and `scl` is 1. The next run restarts with an empty accumulator.
- R10: When the increment exceeds the decrement (increment ≥ modulus), `tick` is high on every running cycle.
- R11: `speed_sel` = 0 selects bank 0 and `speed_sel` = 1 selects bank 1 as the active configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Divider runs while high; when low, clears the divider and locks out nothing |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Bank targeted by a configuration write |
| cfg_wdata | input | 32 | Configuration word: increment [31:16], decrement [15:0] |
| speed_sel | input | 1 | Bank that drives the accumulator |
| tick | output | 1 | Half-period tick pulse |
| scl | output | 1 | SCL square wave, idle high |

## Verification
The assertions assume that `speed_sel` does not change during a run. They also assume the active bank only changes while `run_en` is low, so the accumulator never holds a value from another modulus. The bench meets both assumptions: it changes `speed_sel` and issues its legal writes only between runs, and its one write during a run is the dropped write that R8 targets. Every input changes on the falling clock edge, so each rising edge samples a settled value.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int DIV_FIELD_W = 16;
    localparam int DIV_WORD_W  = 2 * DIV_FIELD_W;
    localparam int DIV_ACC_W   = DIV_FIELD_W + 1;

    // Increment in the upper half, decrement in the lower half of a word.
    typedef struct packed {
        logic [DIV_FIELD_W-1:0] inc;
        logic [DIV_FIELD_W-1:0] dec;
    } div_cfg_t;

    typedef enum logic {
        SPEED_NORMAL = 1'b0,
        SPEED_HIGH   = 1'b1
    } speed_e;

    typedef struct packed {
        logic tick;
        logic scl;
    } scl_out_t;

    function automatic logic [DIV_ACC_W-1:0] cfg_modulus(div_cfg_t c);
        return {1'b0, c.dec} + DIV_ACC_W'(1);
    endfunction

endpackage

// File: rtl/scl_cfg_bank.sv
module scl_cfg_bank
    import scl_div_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int SEL_W     = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        run_en,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  div_cfg_t                    wr_data,
    input  logic [SEL_W-1:0]            act_sel,
    output div_cfg_t [NUM_BANKS-1:0]    bank_q,
    output div_cfg_t                    act_cfg
);

    // One register per bank; writes are locked out while running (R8).
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= '0;
            end else if (wr_en && !run_en && (wr_sel == SEL_W'(g))) begin
                bank_q[g] <= wr_data;
            end
        end
    end

    // Active bank mux (R11); an out-of-range select reads as zero.
    always_comb begin
        act_cfg = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (act_sel == SEL_W'(i)) begin
                act_cfg = bank_q[i];
            end
        end
    end

endmodule

// File: rtl/scl_frac_acc.sv
module scl_frac_acc
    import scl_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_en,
    input  div_cfg_t cfg,
    output logic     hit
);

    logic [DIV_ACC_W-1:0] acc_q;
    logic [DIV_ACC_W-1:0] modulus;
    logic [DIV_ACC_W-1:0] sum;
    logic [DIV_ACC_W-1:0] rem;

    always_comb begin
        modulus = cfg_modulus(cfg);
        sum     = acc_q + {1'b0, cfg.inc};
        rem     = sum - modulus;
        hit     = run_en && (sum >= modulus);
    end

    // Phase accumulator (R4). When the increment is at least one modulus,
    // the remainder is dropped so the tick rate saturates at one per clock (R10).
    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            acc_q <= '0;
        end else if (hit) begin
            acc_q <= (rem >= modulus) ? '0 : rem;
        end else begin
            acc_q <= sum;
        end
    end

endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
    import scl_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_en,
    input  logic     hit,
    output scl_out_t out_q
);

    // Registered tick; SCL flips on each tick and idles high (R5, R9).
    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            out_q.tick <= 1'b0;
            out_q.scl  <= 1'b1;
        end else begin
            out_q.tick <= hit;
            if (hit) begin
                out_q.scl <= ~out_q.scl;
            end
        end
    end

endmodule

// File: rtl/scl_frac_div.sv
module scl_frac_div
    import scl_div_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_en,
    input  logic                  cfg_wr,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [DIV_WORD_W-1:0] cfg_wdata,
    input  logic [SEL_W-1:0]      speed_sel,
    output logic                  tick,
    output logic                  scl
);

    div_cfg_t [NUM_BANKS-1:0] bank_q;
    div_cfg_t                 act_cfg;
    logic                     hit;
    scl_out_t                 wave;

    scl_cfg_bank #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .wr_en   (cfg_wr),
        .wr_sel  (cfg_sel),
        .wr_data (div_cfg_t'(cfg_wdata)),
        .act_sel (speed_sel),
        .bank_q  (bank_q),
        .act_cfg (act_cfg)
    );

    scl_frac_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .cfg    (act_cfg),
        .hit    (hit)
    );

    scl_wave_gen u_wave (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .hit    (hit),
        .out_q  (wave)
    );

    assign tick = wave.tick;
    assign scl  = wave.scl;

endmodule

// File: rtl/scl_frac_div_chk.sv
module scl_frac_div_chk
    import scl_div_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     run_en,
    input logic                     tick,
    input logic                     scl,
    input div_cfg_t                 act_cfg,
    input div_cfg_t [NUM_BANKS-1:0] bank_q
);

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (scl && !tick)); // R9

    AST_SCL_FLIPS: assert property (@(posedge clk) disable iff (rst)
        tick |-> (scl != $past(scl))); // R5

    AST_SCL_STEADY: assert property (@(posedge clk) disable iff (rst)
        ($past(run_en) && !tick) |-> $stable(scl)); // R5

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(run_en)); // R6

    AST_ZERO_INC_SILENT: assert property (@(posedge clk) disable iff (rst)
        (act_cfg.inc == '0) |=> !tick); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        run_en |=> $stable(bank_q)); // R8

    AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (run_en && (act_cfg.inc > act_cfg.dec)) |=> tick); // R10

endmodule

bind scl_frac_div scl_frac_div_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .tick    (tick),
    .scl     (scl),
    .act_cfg (act_cfg),
    .bank_q  (bank_q)
);

// File: tb/scl_frac_div_tb.sv
`timescale 1ns/100ps
module scl_frac_div_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [0:0]  speed_sel = '0;
    logic        tick;
    logic        scl;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        bit    tick;
        bit    scl;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    scl_frac_div u_dut (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .speed_sel (speed_sel),
        .tick      (tick),
        .scl       (scl)
    );

    task automatic check(bit at, bit as, bit et, bit es, string tag);
        checks++;
        if (at !== et || as !== es) begin
            fails++;
            $display("FAIL %s: tick=%0b scl=%0b expected tick=%0b scl=%0b",
                     tag, at, as, et, es);
        end
    endtask

    // Expected tick after the k-th running edge, derived from R4 and R10.
    function automatic bit exp_hit(int k, int inc, int modv);
        if (inc == 0) return 1'b0;
        if (inc >= modv) return 1'b1;
        return ((k * inc) / modv) != (((k - 1) * inc) / modv);
    endfunction

    // Monitor: samples 1 ns after each rising edge and pops the scoreboard.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(tick, scl, e.tick, e.scl, e.tag);
            end
        end
    end

    // Bank write at R2 field positions: increment [31:16], decrement [15:0].
    task automatic write_bank(bit sel, int inc, int dec);
        cfg_wr    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = {inc[15:0], dec[15:0]};
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // Driver: pushes expected (tick, scl) for each running edge, then runs.
    task automatic run_window(int n, int inc, int dec, string tag,
                              bit mid_wr, logic [31:0] mid_word);
        bit s = 1'b1;
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            e.tick = exp_hit(k, inc, dec + 1);
            if (e.tick) s = ~s;
            e.scl = s;
            e.tag = tag;
            exp_q.push_back(e);
        end
        run_en = 1'b1;
        for (int k = 1; k <= n; k++) begin
            if (mid_wr && k == 10) begin
                cfg_wr    = 1'b1;
                cfg_sel   = 1'b0;
                cfg_wdata = mid_word;
            end else begin
                cfg_wr = 1'b0;
            end
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        run_en = 1'b0;
        begin
            exp_t idle;
            idle.tick = 1'b0;
            idle.scl  = 1'b1;
            idle.tag  = "R9 stop";
            exp_q.push_back(idle);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(tick, scl, 1'b0, 1'b1, "R1 reset");
        // R1/R7: banks reset to zero, so a run with no writes stays silent
        run_window(20, 0, 0, "R1 R7 empty banks", 1'b0, '0);

        // R3: standard mode, tick every 500 clocks
        write_bank(1'b0, 1, 499);
        write_bank(1'b1, 0, 0);
        speed_sel = 1'b0;
        run_window(1010, 1, 499, "R3 standard", 1'b0, '0);

        // R3 R6: fast mode, tick every 125 clocks, single-cycle pulses
        write_bank(1'b0, 1, 124);
        run_window(260, 1, 124, "R3 R6 fast", 1'b0, '0);

        // R2: field order; swapped fields would saturate instead
        write_bank(1'b0, 3, 9);
        run_window(40, 3, 9, "R2 layout", 1'b0, '0);

        // R4 R11: high-speed bank, fractional rate 41/153
        write_bank(1'b1, 41, 152);
        write_bank(1'b0, 0, 0);
        speed_sel = 1'b1;
        run_window(320, 41, 152, "R4 R11 highspeed", 1'b0, '0);

        // R7 R11: back to bank 0, which is all zero
        speed_sel = 1'b0;
        run_window(60, 0, 0, "R7 R11 zero bank", 1'b0, '0);

        // R8: write while running is dropped, during and after the run
        write_bank(1'b0, 1, 124);
        run_window(260, 1, 124, "R8 during run", 1'b1, {16'd1, 16'd9});
        run_window(130, 1, 124, "R8 after run", 1'b0, '0);

        // R10: increment above the modulus saturates
        write_bank(1'b0, 5, 2);
        run_window(20, 5, 2, "R10 saturate", 1'b0, '0);

        // R9: stop mid-period, then restart from an empty accumulator
        write_bank(1'b0, 1, 124);
        run_window(60, 1, 124, "R9 partial", 1'b0, '0);
        run_window(130, 1, 124, "R9 restart", 1'b0, '0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule